// File: doc/BRIEF.md
# Edge/Level External Interrupt Latch

This block turns one active-low external interrupt pin into a latched interrupt request for a CPU. The pin is first brought into the clock domain by a synchronizer. A falling edge on the synchronized pin sets a pending latch. Two kinds of acknowledge clear the latch. One is a pulse from the CPU's vector fetch. The other is a software write of 1 to an acknowledge bit in a small control/status register.

A mode bit sets how the clear works. In edge mode an acknowledge clears the latch at once. In level mode the latch stays set while the pin is low, and it clears only after an acknowledge has been seen and the pin has returned high, in either order. A mask bit gates only the request sent to the CPU. The status flag shows the latch whether or not it is masked. The block also outputs the synchronized pin level, and a constant that is the address of the high byte of the interrupt vector.

Top module: `ext_irq_latch`

## Requirements
- R1: A falling edge on `pin_n` sets the pending latch. The latch is visible as CSR bit 3 at most three clock edges after the pin change reaches the input.
- R2: With the mode bit (CSR bit 0) at 0, an acknowledge clears the latch on the next clock edge. An acknowledge is a `vec_ack` pulse, or a CSR write with bit 2 = 1.
- R3: With the mode bit at 1, an acknowledge taken while the synchronized pin is low leaves the latch set.
- R4: With the mode bit at 1, the latch clears once an acknowledge has occurred and the synchronized pin is high, whichever comes last. With no acknowledge, the pin returning high leaves the latch set.
- R5: An acknowledge does not block later edges: a falling edge after an acknowledge sets the latch again. When a falling edge and an acknowledge act in the same cycle, the latch ends up set.
- R6: CSR bit 3 shows the latch whatever the mask bit (CSR bit 1) is. `irq_req` is high only when the latch is set and the mask bit is 0.
- R7: Reset clears the latch, the mode bit and the mask bit. A pin held low through and after reset does not set the latch again.
- R8: `vec_addr` always equals 16'hFFFA. That is the address of the high byte of the vector; the low byte sits at the next address.
- R9: The CSR read layout is {flag, 0, mask, mode}, with bit 2 always reading 0. `pin_level` gives the synchronized pin level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_n | input | 1 | Active-low external interrupt pin, asynchronous |
| reg_wr | input | 1 | CSR write strobe |
| reg_wdata | input | 4 | CSR write data: bit 2 acknowledge, bit 1 mask, bit 0 mode |
| vec_ack | input | 1 | Interrupt-acknowledge pulse from the CPU vector fetch |
| reg_rdata | output | 4 | CSR read data {flag, 0, mask, mode} |
| irq_req | output | 1 | Interrupt request to the CPU |
| pin_level | output | 1 | Synchronized pin level |
| vec_addr | output | 16 | Address of the vector high byte |

## Verification
The hardest case to reach is an acknowledge landing in the exact cycle that a falling edge is detected. That cycle sits behind the two-stage synchronizer. The bench drives the pin low and counts two rising edges. It then raises `vec_ack` for exactly the third edge, so the edge and the clear act together, and checks that the latch stays set. Level mode's hidden "acknowledged" state is reached only by an acknowledge while the pin is low. The bench then observes the clear when the pin rises, and checks the opposite order separately.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int CSR_W    = 4;
  localparam int BIT_FLAG = 3;
  localparam int BIT_ACK  = 2;
  localparam int BIT_MASK = 1;
  localparam int BIT_MODE = 0;

  typedef struct packed {
    logic mask;
    logic mode;
  } irq_ctl_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_lvl,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              prev_q;
  logic              prev_d;

  // Each stage feeds the next; a variant with more stages only changes STAGES.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_comb sh_d[i] = pin_n;
    end else begin : g_rest
      always_comb sh_d[i] = sh_q[i-1];
    end
  end

  always_comb prev_d = sh_q[STAGES-1];

  // Stages reset low, so a pin held low across reset shows no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  assign pin_lvl = sh_q[STAGES-1];
  assign fall    = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CSR_W-1:0] wdata,
  input  logic             flag,
  output irq_ctl_t         ctl,
  output logic             sw_ack,
  output logic [CSR_W-1:0] rdata
);
  irq_ctl_t ctl_q;
  irq_ctl_t ctl_d;

  always_comb begin
    ctl_d.mask = wdata[BIT_MASK];
    ctl_d.mode = wdata[BIT_MODE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (wr) ctl_q <= ctl_d;
  end

  always_comb begin
    rdata           = '0;
    rdata[BIT_FLAG] = flag;
    rdata[BIT_MASK] = ctl_q.mask;
    rdata[BIT_MODE] = ctl_q.mode;
  end

  assign ctl    = ctl_q;
  assign sw_ack = wr & wdata[BIT_ACK];

  assert_mask_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (ctl_q.mask == $past(wdata[BIT_MASK])));
  assert_mode_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> (ctl_q.mode == $past(ctl_q.mode)));
endmodule

// File: rtl/irq_latch_core.sv
module irq_latch_core (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic pin_lvl,
  input  logic mode,
  input  logic ack,
  output logic pending
);
  logic latch_q, latch_d;
  logic acked_q, acked_d;

  always_comb begin
    latch_d = latch_q;
    acked_d = acked_q;
    if (fall) begin
      // A new edge wins over any acknowledge in the same cycle.
      latch_d = 1'b1;
      acked_d = 1'b0;
    end else if (!mode) begin
      acked_d = 1'b0;
      if (ack) latch_d = 1'b0;
    end else if (latch_q && (ack || acked_q)) begin
      if (pin_lvl) begin
        latch_d = 1'b0;
        acked_d = 1'b0;
      end else begin
        acked_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      acked_q <= 1'b0;
    end else begin
      latch_q <= latch_d;
      acked_q <= acked_d;
    end
  end

  assign pending = latch_q;

  assert_fall_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> pending);
  assert_edge_ack_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && ack && !fall) |=> !pending);
  assert_low_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && pending && !pin_lvl) |=> pending);
  assert_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && pending && !ack && !acked_q) |=> pending);
  assert_ack_high_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && pending && acked_q && pin_lvl && !fall) |=> !pending);
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import irq_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] VEC_HI_ADDR = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_n,
  input  logic              reg_wr,
  input  logic [CSR_W-1:0]  reg_wdata,
  input  logic              vec_ack,
  output logic [CSR_W-1:0]  reg_rdata,
  output logic              irq_req,
  output logic              pin_level,
  output logic [ADDR_W-1:0] vec_addr
);
  logic     rst_i;
  logic     fall;
  logic     pin_lvl;
  logic     sw_ack;
  logic     pending;
  irq_ctl_t ctl;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i));

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_i), .pin_n(pin_n), .pin_lvl(pin_lvl), .fall(fall));

  irq_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_i), .wr(reg_wr), .wdata(reg_wdata), .flag(pending),
    .ctl(ctl), .sw_ack(sw_ack), .rdata(reg_rdata));

  irq_latch_core u_core (
    .clk(clk), .rst_n(rst_i), .fall(fall), .pin_lvl(pin_lvl), .mode(ctl.mode),
    .ack(sw_ack | vec_ack), .pending(pending));

  assign irq_req   = pending & ~ctl.mask;
  assign pin_level = pin_lvl;
  assign vec_addr  = ADDR_W'(VEC_HI_ADDR);
endmodule

// File: tb/sim_ext_irq_latch.sv
module sim_ext_irq_latch;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin_n;
  logic       reg_wr;
  logic [3:0] reg_wdata;
  logic       vec_ack;
  logic [3:0] reg_rdata;
  logic       irq_req;
  logic       pin_level;
  logic [15:0] vec_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ext_irq_latch u0 (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .vec_ack(vec_ack), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .pin_level(pin_level), .vec_addr(vec_addr));

  // Row: {wr, wdata[3:0], vack, pin, exp_rdata[3:0], exp_req, exp_pin, req_tag[3:0]}
  localparam int NROWS = 22;
  localparam logic [16:0] TBL [NROWS] = '{
    {1'b0,4'h0,1'b0,1'b0, 4'h8,1'b1,1'b0, 4'd1}, // R1 fall sets
    {1'b1,4'h4,1'b0,1'b0, 4'h0,1'b0,1'b0, 4'd2}, // R2 sw ack clears, edge mode
    {1'b0,4'h0,1'b0,1'b1, 4'h0,1'b0,1'b1, 4'd9}, // R9 pin level high
    {1'b0,4'h0,1'b0,1'b0, 4'h8,1'b1,1'b0, 4'd5}, // R5 edge after ack
    {1'b0,4'h0,1'b1,1'b0, 4'h0,1'b0,1'b0, 4'd2}, // R2 vector ack clears
    {1'b0,4'h0,1'b0,1'b1, 4'h0,1'b0,1'b1, 4'd2}, // R2 rise no effect
    {1'b1,4'h2,1'b0,1'b1, 4'h2,1'b0,1'b1, 4'd6}, // R6 mask set
    {1'b0,4'h0,1'b0,1'b0, 4'hA,1'b0,1'b0, 4'd6}, // R6 flag while masked
    {1'b1,4'h0,1'b0,1'b0, 4'h8,1'b1,1'b0, 4'd6}, // R6 unmask
    {1'b1,4'h4,1'b0,1'b0, 4'h0,1'b0,1'b0, 4'd2}, // R2
    {1'b0,4'h0,1'b0,1'b1, 4'h0,1'b0,1'b1, 4'd9}, // R9
    {1'b1,4'h1,1'b0,1'b1, 4'h1,1'b0,1'b1, 4'd9}, // R9 mode readback
    {1'b0,4'h0,1'b0,1'b0, 4'h9,1'b1,1'b0, 4'd1}, // R1 level mode fall
    {1'b1,4'h5,1'b0,1'b0, 4'h9,1'b1,1'b0, 4'd3}, // R3 ack while low holds
    {1'b0,4'h0,1'b0,1'b1, 4'h1,1'b0,1'b1, 4'd4}, // R4 then high clears
    {1'b0,4'h0,1'b0,1'b0, 4'h9,1'b1,1'b0, 4'd1}, // R1
    {1'b0,4'h0,1'b0,1'b1, 4'h9,1'b1,1'b1, 4'd4}, // R4 high without ack holds
    {1'b0,4'h0,1'b1,1'b1, 4'h1,1'b0,1'b1, 4'd4}, // R4 ack after high clears
    {1'b0,4'h0,1'b0,1'b0, 4'h9,1'b1,1'b0, 4'd1}, // R1
    {1'b0,4'h0,1'b1,1'b0, 4'h9,1'b1,1'b0, 4'd3}, // R3 vector ack while low
    {1'b1,4'h3,1'b0,1'b0, 4'hB,1'b0,1'b0, 4'd6}, // R6 masked in level mode
    {1'b1,4'h1,1'b0,1'b0, 4'h9,1'b1,1'b0, 4'd6}  // R6 unmask
  };

  task automatic check(input string tag, input logic [3:0] rd, input logic rq, input logic pl);
    checks++;
    if (reg_rdata !== rd || irq_req !== rq || pin_level !== pl) begin
      fails++;
      $display("FAIL %s: rdata=%h req=%b pin=%b expected rdata=%h req=%b pin=%b",
               tag, reg_rdata, irq_req, pin_level, rd, rq, pl);
    end
  endtask

  task automatic step(input logic wr, input logic [3:0] wd, input logic va, input logic pin);
    @(negedge clk);
    pin_n = pin; reg_wr = wr; reg_wdata = wd; vec_ack = va;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 4'h0; vec_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_n = 1'b1; reg_wr = 1'b0; reg_wdata = 4'h0; vec_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R7 reset state", 4'h0, 1'b0, 1'b1);
    checks++;
    if (vec_addr !== 16'hFFFA) begin
      fails++;
      $display("FAIL R8: vec_addr=%h expected=%h", vec_addr, 16'hFFFA);
    end

    for (int i = 0; i < NROWS; i++) begin
      logic [16:0] r;
      r = TBL[i];
      step(r[16], r[15:12], r[11], r[10]);
      check($sformatf("R%0d row %0d", r[3:0], i), r[9:6], r[5], r[4]);
    end

    // R5: an edge and an acknowledge act in the same cycle; the edge wins.
    step(1'b1, 4'h0, 1'b0, 1'b0);
    check("R2 back to edge mode", 4'h8, 1'b1, 1'b0);
    step(1'b0, 4'h0, 1'b0, 1'b1);
    check("R2 rise keeps latch", 4'h8, 1'b1, 1'b1);
    @(negedge clk) pin_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) vec_ack = 1'b1;
    @(posedge clk);
    @(negedge clk) vec_ack = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R5 edge beats same-cycle ack", 4'h8, 1'b1, 1'b0);
    step(1'b0, 4'h0, 1'b1, 1'b0);
    check("R2 ack after edge clears", 4'h0, 1'b0, 1'b0);

    // R7: reset with the pin held low.
    step(1'b1, 4'h1, 1'b0, 1'b1);
    step(1'b0, 4'h0, 1'b0, 1'b0);
    check("R1 set before reset", 4'h9, 1'b1, 1'b0);
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 reset clears", 4'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    check("R7 low pin after reset no relatch", 4'h0, 1'b0, 1'b0);
    checks++;
    if (vec_addr !== 16'hFFFA) begin
      fails++;
      $display("FAIL R8: vec_addr=%h expected=%h", vec_addr, 16'hFFFA);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule